// File: doc/BRIEF.md
# Next-PC Sequencing Unit

This block owns the program counter of a simple in-order core and decides, every cycle it is enabled, where the next fetch goes. It looks at the current 32-bit instruction word together with the two source register values read for it, recognises the control-flow opcodes, and selects one of three addresses: the following word, a branch target relative to the following word, or a pseudo-direct jump target.

Branch displacements are signed word counts, so a branch can move forward or backward. Jump targets keep the upper address bits of the current PC and replace the rest with the word index carried in the instruction. The unit also presents the incremented PC as the return address for a call, and flags when that value is meaningful.

Top module: `pc_sequencer`

## Requirements
- R1: While rst_ni is low the PC is 0x0000_0000, and the first enabled edge after release advances from that value.
- R2: When en_i is low on a clock edge, pc_o keeps its value, whatever the instruction.
- R3: Any opcode (instr_i[31:26]) other than 2, 3, 4 or 5 drives taken_o low and loads pc_o + 4.
- R4: Opcode 4 with rs_val_i equal to rt_val_i drives taken_o high and loads (pc_o + 4) + 4 × the signed 16-bit field instr_i[15:0].
- R5: Opcode 5 with rs_val_i differing from rt_val_i drives taken_o high and loads the same branch target as R4.
- R6: A branch whose condition fails (opcode 4 with unequal values, opcode 5 with equal values) drives taken_o low and loads pc_o + 4.
- R7: Opcode 2 drives taken_o high and loads pc_o[31:28], then instr_i[25:0], then two zero bits.
- R8: Opcode 3 loads the same target as R7, drives taken_o high and raises link_valid_o, while pc_plus4_o carries pc_o + 4 as the return address.
- R9: pc_plus4_o always equals pc_o + 4, and link_valid_o is low for every opcode other than 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Advance enable; low stalls the PC |
| instr_i | input | 32 | Instruction word at pc_o |
| rs_val_i | input | 32 | First source register value |
| rt_val_i | input | 32 | Second source register value |
| pc_o | output | 32 | Current program counter |
| pc_plus4_o | output | 32 | pc_o + 4, also the return address |
| taken_o | output | 1 | Current instruction redirects fetch |
| link_valid_o | output | 1 | Current instruction is a jump-and-link |

## Verification
The hardest case to reach from the ports is a jump issued while the upper four PC bits are non-zero, since reset starts at zero, jumps preserve those bits and sequential fetch would need tens of millions of cycles to carry into them. The bench climbs there with a chain of taken equal-branches using the largest forward displacement, each adding 0x20000, so 2048 of them reach 0x1000_0000; it then issues jump and jump-and-link there and a negative-offset branch that steps backward.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  localparam int unsigned OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_JMP = 6'd2;
  localparam logic [OPC_W-1:0] OPC_JAL = 6'd3;
  localparam logic [OPC_W-1:0] OPC_BEQ = 6'd4;
  localparam logic [OPC_W-1:0] OPC_BNE = 6'd5;

  typedef enum logic [2:0] {
    KIND_SEQ = 3'd0,
    KIND_BEQ = 3'd1,
    KIND_BNE = 3'd2,
    KIND_JMP = 3'd3,
    KIND_JAL = 3'd4
  } cf_kind_e;

  typedef enum logic [1:0] {
    SEL_SEQ = 2'd0,
    SEL_BR  = 2'd1,
    SEL_JMP = 2'd2
  } next_sel_e;
endpackage

// File: rtl/pcseq_decode.sv
module pcseq_decode
  import pcseq_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  output cf_kind_e         kind_o
);
  always_comb begin
    unique case (opcode_i)
      OPC_JMP: kind_o = KIND_JMP;
      OPC_JAL: kind_o = KIND_JAL;
      OPC_BEQ: kind_o = KIND_BEQ;
      OPC_BNE: kind_o = KIND_BNE;
      default: kind_o = KIND_SEQ;
    endcase
  end
endmodule

// File: rtl/pcseq_cond.sv
module pcseq_cond
  import pcseq_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  cf_kind_e        kind_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output next_sel_e       sel_o,
  output logic            taken_o,
  output logic            link_o
);
  logic same;
  assign same = (a_i == b_i);

  always_comb begin
    sel_o   = SEL_SEQ;
    taken_o = 1'b0;
    link_o  = 1'b0;
    unique case (kind_i)
      KIND_BEQ: if (same)  begin sel_o = SEL_BR; taken_o = 1'b1; end
      KIND_BNE: if (!same) begin sel_o = SEL_BR; taken_o = 1'b1; end
      KIND_JMP: begin sel_o = SEL_JMP; taken_o = 1'b1; end
      KIND_JAL: begin sel_o = SEL_JMP; taken_o = 1'b1; link_o = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/pcseq_target.sv
module pcseq_target #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned IMM_W  = 16,
  parameter int unsigned JIDX_W = 26
) (
  input  logic [XLEN-1:0]   pc_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [JIDX_W-1:0] jidx_i,
  output logic [XLEN-1:0]   seq_o,
  output logic [XLEN-1:0]   br_o,
  output logic [XLEN-1:0]   jmp_o
);
  localparam int unsigned SH    = 2;                    // word to byte scaling
  localparam int unsigned EXT_W = XLEN - IMM_W - SH;
  localparam int unsigned TOP_W = XLEN - JIDX_W - SH;

  logic [XLEN-1:0] disp;

  assign seq_o = pc_i + XLEN'(4);
  assign disp  = {{EXT_W{imm_i[IMM_W-1]}}, imm_i, {SH{1'b0}}};
  assign br_o  = seq_o + disp;
  // upper bits come from the instruction's own address, not the incremented one
  assign jmp_o = {pc_i[XLEN-1 -: TOP_W], jidx_i, {SH{1'b0}}};
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcseq_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned IMM_W  = 16,
  parameter int unsigned JIDX_W = 26
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [XLEN-1:0] instr_i,
  input  logic [XLEN-1:0] rs_val_i,
  input  logic [XLEN-1:0] rt_val_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] pc_plus4_o,
  output logic            taken_o,
  output logic            link_valid_o
);
  logic [XLEN-1:0] pc_q, pc_d;
  logic [XLEN-1:0] seq_addr, br_addr, jmp_addr;
  cf_kind_e        kind;
  next_sel_e       sel;

  pcseq_decode u_dec (
    .opcode_i (instr_i[XLEN-1 -: OPC_W]),
    .kind_o   (kind)
  );

  pcseq_cond #(.XLEN(XLEN)) u_cond (
    .kind_i  (kind),
    .a_i     (rs_val_i),
    .b_i     (rt_val_i),
    .sel_o   (sel),
    .taken_o (taken_o),
    .link_o  (link_valid_o)
  );

  pcseq_target #(.XLEN(XLEN), .IMM_W(IMM_W), .JIDX_W(JIDX_W)) u_tgt (
    .pc_i   (pc_q),
    .imm_i  (instr_i[IMM_W-1:0]),
    .jidx_i (instr_i[JIDX_W-1:0]),
    .seq_o  (seq_addr),
    .br_o   (br_addr),
    .jmp_o  (jmp_addr)
  );

  always_comb begin
    unique case (sel)
      SEL_BR:  pc_d = br_addr;
      SEL_JMP: pc_d = jmp_addr;
      default: pc_d = seq_addr;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pc_q <= '0;
    else if (en_i) pc_q <= pc_d;
  end

  assign pc_o       = pc_q;
  assign pc_plus4_o = seq_addr;
endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            en_i,
  input logic [XLEN-1:0] instr_i,
  input logic [XLEN-1:0] rs_val_i,
  input logic [XLEN-1:0] rt_val_i,
  input logic [XLEN-1:0] pc_o,
  input logic [XLEN-1:0] pc_plus4_o,
  input logic            taken_o,
  input logic            link_valid_o
);
  logic [5:0]      op;
  logic            is_cf;
  logic [XLEN-1:0] bdisp;
  logic [XLEN-1:0] jdest;

  assign op    = instr_i[XLEN-1 -: 6];
  assign is_cf = (op == 6'd2) || (op == 6'd3) || (op == 6'd4) || (op == 6'd5);
  assign bdisp = {{(XLEN-18){instr_i[15]}}, instr_i[15:0], 2'b00};
  assign jdest = {pc_o[XLEN-1 -: 4], instr_i[25:0], 2'b00};

  assert_reset_zero_R1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> pc_o == '0);

  assert_stall_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(pc_o));

  assert_seq_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !is_cf) |=> pc_o == $past(pc_plus4_o));

  assert_beq_target_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op == 6'd4 && rs_val_i == rt_val_i) |=> pc_o == $past(pc_o) + XLEN'(4) + $past(bdisp));

  assert_bne_target_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op == 6'd5 && rs_val_i != rt_val_i) |=> pc_o == $past(pc_o) + XLEN'(4) + $past(bdisp));

  assert_taken_only_cf_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> is_cf);

  assert_jump_target_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (op == 6'd2 || op == 6'd3)) |=> pc_o == $past(jdest));

  assert_link_ret_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_valid_o |-> (op == 6'd3 && taken_o && pc_plus4_o == pc_o + XLEN'(4)));

  assert_plus4_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_plus4_o == pc_o + XLEN'(4));
endmodule

bind pc_sequencer pc_sequencer_chk #(.XLEN(XLEN)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .instr_i      (instr_i),
  .rs_val_i     (rs_val_i),
  .rt_val_i     (rt_val_i),
  .pc_o         (pc_o),
  .pc_plus4_o   (pc_plus4_o),
  .taken_o      (taken_o),
  .link_valid_o (link_valid_o)
);

// File: tb/pc_sequencer_test.sv
module pc_sequencer_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic        en_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [31:0] rs_val_i = '0;
  logic [31:0] rt_val_i = '0;
  logic [31:0] pc_o, pc_plus4_o;
  logic        taken_o, link_valid_o;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_pc = '0;

  always #4 clk_i = ~clk_i;

  pc_sequencer uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .instr_i(instr_i),
    .rs_val_i(rs_val_i), .rt_val_i(rt_val_i), .pc_o(pc_o),
    .pc_plus4_o(pc_plus4_o), .taken_o(taken_o), .link_valid_o(link_valid_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ityp(input logic [5:0] op, input logic [15:0] imm);
    return {op, 5'd8, 5'd9, imm};
  endfunction

  // drive after falling edge, check combinational outputs, then the registered PC
  task automatic issue(input string tag, input logic [31:0] ins, input logic [31:0] a,
                       input logic [31:0] b, input logic en, input logic exp_tk,
                       input logic exp_lk, input logic [31:0] nxt);
    @(negedge clk_i);
    instr_i = ins; rs_val_i = a; rt_val_i = b; en_i = en;
    #1;
    chk({tag, " taken"}, {31'd0, taken_o}, {31'd0, exp_tk});
    chk({tag, " link"}, {31'd0, link_valid_o}, {31'd0, exp_lk});
    chk({tag, " plus4 R9"}, pc_plus4_o, exp_pc + 32'd4);
    @(posedge clk_i); #1;
    chk({tag, " pc"}, pc_o, nxt);
    exp_pc = nxt;
    en_i = 1'b0;
  endtask

  task automatic t_reset;
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    #1 chk("R1 pc in reset", pc_o, 32'h0);
    @(negedge clk_i) rst_ni = 1'b1;
    exp_pc = '0;
    issue("R1 first step", 32'h0000_0020, 0, 0, 1'b1, 1'b0, 1'b0, 32'h4);
  endtask

  task automatic t_seq;
    issue("R3 add", 32'h0232_4020, 1, 2, 1'b1, 1'b0, 1'b0, exp_pc + 4);
    issue("R3 load op35", ityp(6'd35, 16'h0), 3, 3, 1'b1, 1'b0, 1'b0, exp_pc + 4);
    issue("R3 op63", ityp(6'd63, 16'hffff), 5, 5, 1'b1, 1'b0, 1'b0, exp_pc + 4);
  endtask

  task automatic t_stall;
    issue("R2 stall jump", {6'd2, 26'h3ff_ffff}, 0, 0, 1'b0, 1'b1, 1'b0, exp_pc);
    issue("R2 stall beq", ityp(6'd4, 16'h0100), 7, 7, 1'b0, 1'b1, 1'b0, exp_pc);
  endtask

  task automatic t_branch;
    issue("R4 beq fwd", ityp(6'd4, 16'h0003), 9, 9, 1'b1, 1'b1, 1'b0, exp_pc + 4 + 12);
    issue("R6 beq not", ityp(6'd4, 16'h0003), 9, 8, 1'b1, 1'b0, 1'b0, exp_pc + 4);
    issue("R5 bne fwd", ityp(6'd5, 16'h0010), 1, 2, 1'b1, 1'b1, 1'b0, exp_pc + 4 + 64);
    issue("R6 bne not", ityp(6'd5, 16'h0010), 4, 4, 1'b1, 1'b0, 1'b0, exp_pc + 4);
    issue("R4 beq back", ityp(6'd4, 16'hfffe), 0, 0, 1'b1, 1'b1, 1'b0, exp_pc - 4);
    issue("R5 bne back", ityp(6'd5, 16'hfff0), 1, 0, 1'b1, 1'b1, 1'b0, exp_pc + 4 - 64);
  endtask

  // R4: largest forward equal-branch adds 0x20000; 2048 of them reach the next 256MB region
  task automatic t_climb;
    logic [31:0] start;
    start = exp_pc;
    for (int i = 0; i < 2048; i++)
      issue("R4 climb", ityp(6'd4, 16'h7fff), 1, 1, 1'b1, 1'b1, 1'b0, exp_pc + 32'h0002_0000);
    chk("R4 climb top bits", exp_pc, start + 32'h1000_0000);
  endtask

  task automatic t_jump;
    logic [31:0] hi;
    hi = exp_pc & 32'hf000_0000;
    chk("R7 high region", hi, 32'h1000_0000);
    issue("R7 jump hi", {6'd2, 26'h123_4567}, 0, 1, 1'b1, 1'b1, 1'b0, hi | (32'h123_4567 << 2));
    issue("R8 jal hi", {6'd3, 26'h000_0040}, 0, 0, 1'b1, 1'b1, 1'b1, hi | 32'h100);
    issue("R4 back hi", ityp(6'd4, 16'h8000), 2, 2, 1'b1, 1'b1, 1'b0, exp_pc + 4 - 32'h0002_0000);
    issue("R9 seq after", 32'h0, 0, 0, 1'b1, 1'b0, 1'b0, exp_pc + 4);
  endtask

  initial begin
    t_reset();
    t_seq();
    t_stall();
    t_branch();
    t_climb();
    t_jump();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule